// File: doc/BRIEF.md
# LIN Physical-Layer Mode Sequencer

This block is the digital controller that decides which operating mode a LIN bus transceiver is in. It watches a chip-select/wake pin driven by the host controller, the received bus level, and a set of digital status flags from the analog side: regulator output stable, battery above the start threshold, regulator undervoltage, thermal shutdown and output overload. From these it drives the regulator enable, the transmitter enable and a 3-bit mode code.

Mode changes are caused by edges of the pin, never by its level. The one exception is the power-on entry, where the pin level is read once to pick one of two ready states. After the regulator reports a stable output, the pin is blanked for a programmable number of cycles, and edges that arrive in that time are discarded. From the low-power state the block can be woken by a falling edge on the bus, which brings the regulator up first and then enters the ready state. It can also be woken by a rising pin edge, which goes straight to transmitting. Any fault returns the block to the second ready state. A regulator undervoltage shuts everything down until the battery flag shows enough headroom again.

Top module: `lin_mode_seq`

## Requirements
- R1: During and right after reset the mode is POR (code 0), with the regulator and transmitter enables both low. POR is held while the battery-start flag is low.
- R2: When the battery-start flag is high in POR, the block leaves POR. A low synchronised pin selects Ready (code 1) and a high one selects Ready1 (code 2).
- R3: Ready1 goes to Ready on a falling pin edge. Ready goes to Operation (code 3) on a rising pin edge. Operation goes to Power-down (code 4) on a falling pin edge. A steady pin level causes no transition.
- R4: For BLANK_CYCLES cycles after the regulator-stable flag rises, and whenever that flag is low outside Power-down, pin edges are discarded. A discarded edge has no effect after the window closes.
- R5: In Power-down, with no wake pending, the regulator and transmitter enables are both low.
- R6: In Power-down a falling bus edge raises the regulator enable while the mode stays 4. Once the regulator-stable flag is high, the mode becomes Ready. A rising pin edge in Power-down goes to Operation, with no blanking applied. A falling bus edge outside Power-down has no effect.
- R7: The transmitter enable is high only in Operation. The regulator enable is high in Ready, Ready1 and Operation.
- R8: Power-down is entered only from Operation. A falling pin edge in Ready leaves the mode at Ready.
- R9: A thermal or overload flag in Ready, Ready1 or Operation moves the mode to Ready1 at the next clock edge. Pin edges are ignored while the fault stays high.
- R10: The undervoltage flag in Ready, Ready1 or Operation moves the mode to POR at the next clock edge, with the regulator enable low. Restart follows R2.
- R11: The pin and the bus input each pass through a two-flop synchroniser and an edge detector. A pin change applied between clock edges is reflected in the mode after the third rising edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_wake_i | input | 1 | Chip-select/wake pin, asynchronous |
| bus_rx_i | input | 1 | Received bus level, asynchronous, high = recessive |
| vreg_ok_i | input | 1 | Regulator output reported stable |
| vbat_start_i | input | 1 | Battery above start threshold |
| vreg_uv_i | input | 1 | Regulator output below shutdown threshold |
| thermal_i | input | 1 | Thermal shutdown flag |
| overload_i | input | 1 | Bus or regulator overload flag |
| reg_en_o | output | 1 | Regulator enable |
| tx_en_o | output | 1 | Transmitter enable |
| mode_o | output | 3 | Mode: 0 POR, 1 Ready, 2 Ready1, 3 Operation, 4 Power-down |

## Verification
Every state drives its enables straight from the mode register, so a wrong state shows at mode_o and at the enables in the same cycle. A wrongly taken or missed pin edge appears exactly three edges after the pin moves. Blanking errors are the slowest to show: a queued edge only surfaces once the window closes, so the bench holds the pin for longer than the window and then checks that the mode has not moved. A lost wake request shows as a regulator enable that never rises after the bus falls.

// File: rtl/lin_mode_pkg.sv
package lin_mode_pkg;

  typedef enum logic [2:0] {
    MODE_POR    = 3'd0,
    MODE_READY  = 3'd1,
    MODE_READY1 = 3'd2,
    MODE_OPER   = 3'd3,
    MODE_PDOWN  = 3'd4
  } lin_mode_e;

  // Regulator is powered in every ready/operate state, and in
  // power-down once a bus wake request is pending.
  function automatic logic reg_power(lin_mode_e m, logic wake);
    return (m == MODE_READY) || (m == MODE_READY1) || (m == MODE_OPER) ||
           ((m == MODE_PDOWN) && wake);
  endfunction

  // Regulator-backed states where faults and undervoltage act.
  function automatic logic powered_state(lin_mode_e m);
    return (m == MODE_READY) || (m == MODE_READY1) || (m == MODE_OPER);
  endfunction

endpackage

// File: rtl/lin_sync_edge.sv
module lin_sync_edge #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its delayed copy
  logic [STAGES:0] pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= {(STAGES+1){RST_VAL}};
    else        pipe <= {pipe[STAGES-1:0], d_i};
  end

  assign level_o = pipe[STAGES-1];
  assign rise_o  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall_o  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/lin_blank_timer.sv
module lin_blank_timer #(
  parameter int CYCLES = 60000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vok_i,
  output logic blank_o
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic          vok_q;
  logic [CW-1:0] cnt;
  logic          vok_rise;

  assign vok_rise = vok_i & ~vok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vok_q <= 1'b0;
      cnt   <= '0;
    end else begin
      vok_q <= vok_i;
      if (vok_rise)        cnt <= LOAD;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
    end
  end

  assign blank_o = ~vok_i | vok_rise | (cnt != '0);
endmodule

// File: rtl/lin_mode_fsm.sv
module lin_mode_fsm
  import lin_mode_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      pin_level,
  input  logic      pin_rise,
  input  logic      pin_fall,
  input  logic      bus_fall,
  input  logic      blank,
  input  logic      vok,
  input  logic      vbat_ok,
  input  logic      uv,
  input  logic      fault,
  output lin_mode_e mode,
  output logic      wake_pend
);
  lin_mode_e mode_n;
  logic      wake_n;
  logic      pin_ok;

  assign pin_ok = ~blank & ~fault;

  always_comb begin
    mode_n = mode;
    wake_n = wake_pend;
    case (mode)
      MODE_POR: begin
        wake_n = 1'b0;
        if (vbat_ok) mode_n = pin_level ? MODE_READY1 : MODE_READY;
      end
      MODE_READY: begin
        if (uv)                     mode_n = MODE_POR;
        else if (fault)             mode_n = MODE_READY1;
        else if (pin_ok && pin_rise) mode_n = MODE_OPER;
      end
      MODE_READY1: begin
        if (uv)                     mode_n = MODE_POR;
        else if (fault)             mode_n = MODE_READY1;
        else if (pin_ok && pin_fall) mode_n = MODE_READY;
      end
      MODE_OPER: begin
        if (uv)                     mode_n = MODE_POR;
        else if (fault)             mode_n = MODE_READY1;
        else if (pin_ok && pin_fall) mode_n = MODE_PDOWN;
      end
      MODE_PDOWN: begin
        if (pin_rise) begin
          mode_n = MODE_OPER;
          wake_n = 1'b0;
        end else if (wake_pend && vok) begin
          mode_n = MODE_READY;
          wake_n = 1'b0;
        end else if (bus_fall) begin
          wake_n = 1'b1;
        end
      end
      default: begin
        mode_n = MODE_POR;
        wake_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= MODE_POR;
      wake_pend <= 1'b0;
    end else begin
      mode      <= mode_n;
      wake_pend <= wake_n;
    end
  end
endmodule

// File: rtl/lin_mode_seq.sv
module lin_mode_seq
  import lin_mode_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 60000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_wake_i,
  input  logic       bus_rx_i,
  input  logic       vreg_ok_i,
  input  logic       vbat_start_i,
  input  logic       vreg_uv_i,
  input  logic       thermal_i,
  input  logic       overload_i,
  output logic       reg_en_o,
  output logic       tx_en_o,
  output logic [2:0] mode_o
);
  localparam int NSYNC = 2;   // index 0: pin, index 1: bus
  localparam logic [NSYNC-1:0] SYNC_RST = 2'b10;

  logic [NSYNC-1:0] raw_in, lvl, rise, fall;
  logic             blank_w;
  logic             fault_w;
  logic             wake_pend_w;
  lin_mode_e        mode_w;

  assign raw_in  = {bus_rx_i, cs_wake_i};
  assign fault_w = thermal_i | overload_i;

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    lin_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST[g])) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    (raw_in[g]),
      .level_o(lvl[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end

  lin_blank_timer #(.CYCLES(BLANK_CYCLES)) u_blank (
    .clk    (clk),
    .rst_n  (rst_n),
    .vok_i  (vreg_ok_i),
    .blank_o(blank_w)
  );

  lin_mode_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_level(lvl[0]),
    .pin_rise (rise[0]),
    .pin_fall (fall[0]),
    .bus_fall (fall[1]),
    .blank    (blank_w),
    .vok      (vreg_ok_i),
    .vbat_ok  (vbat_start_i),
    .uv       (vreg_uv_i),
    .fault    (fault_w),
    .mode     (mode_w),
    .wake_pend(wake_pend_w)
  );

  assign mode_o   = mode_w;
  assign reg_en_o = reg_power(mode_w, wake_pend_w);
  assign tx_en_o  = (mode_w == MODE_OPER);

  logic unused_ok;
  assign unused_ok = ^{lvl[1], rise[1]};
endmodule

// File: rtl/lin_mode_seq_chk.sv
module lin_mode_seq_chk
  import lin_mode_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] mode_o,
  input logic       reg_en_o,
  input logic       tx_en_o,
  input logic       wake_pend,
  input logic       blank,
  input logic       fault,
  input logic       vreg_uv_i
);
  logic powered;
  assign powered = (mode_o == MODE_READY) || (mode_o == MODE_READY1) ||
                   (mode_o == MODE_OPER);

  p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o <= 3'd4);

  p_tx_only_oper_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en_o |-> (mode_o == MODE_OPER));

  p_pdown_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_PDOWN && !wake_pend) |-> (!reg_en_o && !tx_en_o));

  p_pdown_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_PDOWN && $past(mode_o) != MODE_PDOWN) |->
      ($past(mode_o) == MODE_OPER));

  p_blank_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_OPER && $past(mode_o) == MODE_READY) |-> !$past(blank));

  p_fault_ready1_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && fault && !vreg_uv_i) |=> (mode_o == MODE_READY1));

  p_uv_shutdown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (powered && vreg_uv_i) |=> (mode_o == MODE_POR && !reg_en_o));
endmodule

bind lin_mode_seq lin_mode_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode_o   (mode_o),
  .reg_en_o (reg_en_o),
  .tx_en_o  (tx_en_o),
  .wake_pend(wake_pend_w),
  .blank    (blank_w),
  .fault    (fault_w),
  .vreg_uv_i(vreg_uv_i)
);

// File: tb/lin_mode_seq_test.sv
`timescale 1ns/1ps
module lin_mode_seq_test;
  localparam int BLANK = 20;
  localparam int SETTLE = 30;
  localparam int NVEC = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, bus = 1'b1, vok = 1'b0, vbat = 1'b0;
  logic uv = 1'b0, th = 1'b0, ov = 1'b0;
  logic reg_en, tx_en;
  logic [2:0] mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lin_mode_seq #(.SYNC_STAGES(2), .BLANK_CYCLES(BLANK)) uut (
    .clk(clk), .rst_n(rst_n), .cs_wake_i(cs), .bus_rx_i(bus),
    .vreg_ok_i(vok), .vbat_start_i(vbat), .vreg_uv_i(uv),
    .thermal_i(th), .overload_i(ov),
    .reg_en_o(reg_en), .tx_en_o(tx_en), .mode_o(mode)
  );

  // {cs,bus,vok,vbat,uv,th,ov} _ mode _ reg,tx
  localparam logic [11:0] VEC [NVEC] = '{
    12'b0100000_000_00,  // R1 POR held, battery low
    12'b0101000_001_10,  // R2 pin low -> Ready, R7 reg on
    12'b0111000_001_10,  // R4 regulator stable, window opens
    12'b1111000_011_11,  // R3 Ready rise -> Operation, R7 tx on
    12'b0111000_100_00,  // R3 fall -> Power-down, R5 all off
    12'b0001000_100_10,  // R6 bus falls: regulator on, still mode 4
    12'b0111000_001_10,  // R6 stable -> Ready
    12'b1111000_011_11,  // R3 Operation
    12'b1111010_010_10,  // R9 thermal -> Ready1
    12'b1111000_010_10,  // R9 stays Ready1 after recovery
    12'b0111000_001_10,  // R3 Ready1 fall -> Ready
    12'b1111000_011_11,  // R3 Operation
    12'b1100100_000_00,  // R10 undervoltage -> POR, regulator off
    12'b1101000_010_10,  // R2 pin high -> Ready1
    12'b1111000_010_10,  // R4 window opens
    12'b0111000_001_10,  // R3 Ready1 -> Ready
    12'b1111000_011_11,  // R3 Operation
    12'b0111000_100_00,  // R3 Power-down
    12'b1111000_011_11   // R6 pin rise in Power-down -> Operation
  };

  task automatic chk(input string req, input logic [2:0] em, input logic er, input logic et);
    checks++;
    if (mode !== em || reg_en !== er || tx_en !== et) begin
      errors++;
      $display("FAIL %s: mode=%0d reg=%0b tx=%0b expected mode=%0d reg=%0b tx=%0b",
               req, mode, reg_en, tx_en, em, er, et);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      finish_run();
    end
  end

  initial begin
    cyc(4);
    chk("R1 in reset", 3'd0, 1'b0, 1'b0);
    rst_n = 1'b1;
    cyc(3);
    chk("R1 after reset", 3'd0, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      {cs, bus, vok, vbat, uv, th, ov} = VEC[i][11:5];
      cyc(SETTLE);
      chk($sformatf("table step %0d", i), VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end

    // R11: pin fall in Operation shows after exactly three edges
    cs = 1'b0;
    cyc(2);
    chk("R11 not before third edge", 3'd3, 1'b1, 1'b1);
    cyc(1);
    chk("R11 third edge", 3'd4, 1'b0, 1'b0);

    // R6: bus wake with regulator already stable -> Ready
    bus = 1'b0;
    cyc(10);
    chk("R6 bus wake", 3'd1, 1'b1, 1'b0);
    bus = 1'b1; cyc(5); bus = 1'b0; cyc(10);
    chk("R6 bus fall ignored in Ready", 3'd1, 1'b1, 1'b0);
    bus = 1'b1;

    // R4: edge inside window discarded, not queued
    vok = 1'b0; cyc(3); vok = 1'b1;
    cyc(5);
    cs = 1'b1;
    cyc(40);
    chk("R4 blanked rise discarded", 3'd1, 1'b1, 1'b0);
    // R8: falling pin in Ready does not reach Power-down
    cs = 1'b0; cyc(10);
    chk("R8 no power-down from Ready", 3'd1, 1'b1, 1'b0);
    cs = 1'b1; cyc(10);
    chk("R3 rise after window", 3'd3, 1'b1, 1'b1);

    // R9: overload -> Ready1 at next edge, pin ignored while high
    ov = 1'b1; cyc(1);
    chk("R9 overload next edge", 3'd2, 1'b1, 1'b0);
    cs = 1'b0; cyc(10);
    chk("R9 pin ignored during fault", 3'd2, 1'b1, 1'b0);
    ov = 1'b0; cs = 1'b1; cyc(10); cs = 1'b0; cyc(10);
    chk("R9 toggle after recovery", 3'd1, 1'b1, 1'b0);

    // R10: undervoltage -> POR next edge, waits for battery flag
    uv = 1'b1; vbat = 1'b0; cyc(1);
    chk("R10 undervoltage next edge", 3'd0, 1'b0, 1'b0);
    uv = 1'b0; cyc(10);
    chk("R10 held without battery", 3'd0, 1'b0, 1'b0);
    vbat = 1'b1; cyc(3);
    chk("R2 restart pin low", 3'd1, 1'b1, 1'b0);

    done = 1'b1;
    finish_run();
  end
endmodule